// File: doc/BRIEF.md
# Single-Wire Pulse-Coded Command Sender

This block puts one command byte onto a shared serial line that has a pull-up and is driven open-drain. The line rests high. The block signals each symbol by pulling the line low for a short or a long part of a fixed symbol window. A long low stretch means 0 and a short one means 1. After the eight data symbols comes a closing stop symbol. The block then releases the line so the far device can use the same wire to answer.

A host pulses `start` for one cycle and supplies `cmd` in the same cycle. While the frame is on the wire, `busy` stays high. `done` pulses once when the frame has finished. The output `lineLow` is a registered pull-down enable for an external tristate pad. When it is high the pad drives 0. When it is low the pad floats and the pull-up holds the line high. At a 4 MHz clock, one symbol lasts 4 us. The usual command is 0x01.

Top module: `swire_req_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `lineLow`=0, `busy`=0 and `done`=0.
- R2: When `start`=1 is seen at a clock edge while `busy`=0, `lineLow` and `busy` are both 1 in the cycle that follows. This gives the falling edge that opens the frame.
- R3: A 0 data bit takes 16 cycles: `lineLow`=1 for the first 12 cycles, then `lineLow`=0 for 4 cycles.
- R4: A 1 data bit takes 16 cycles: `lineLow`=1 for the first 4 cycles, then `lineLow`=0 for 12 cycles.
- R5: The data bits go out from `cmd[7]` down to `cmd[0]`, in that order.
- R6: Every symbol starts right after the previous one ends, with no gap, so a frame fills exactly 144 cycles after the start edge.
- R7: The ninth symbol is a stop symbol with the same timing as a 1. After it, `lineLow` stays 0.
- R8: In the cycle just after the frame's last cycle, `done`=1 and `busy`=0. In the cycle after that, `done` is back to 0.
- R9: While `busy`=1, a `start` pulse and any change on `cmd` have no effect on the frame in progress. The value of `cmd` is captured only at the accepted start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz symbol-timing clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to send `cmd` |
| cmd | input | 8 | Command byte, sampled when a start is accepted |
| lineLow | output | 1 | Registered pull-down enable (1 = drive low, 0 = release) |
| busy | output | 1 | High while a frame is on the line |
| done | output | 1 | One-cycle pulse after the stop symbol |

## Verification
A phase counter that is off by one makes a low stretch 11 or 13 cycles long, which shows on `lineLow` in the first symbol. A symbol index or shift register that is out of step sends bits in the wrong order, or misplaces the stop symbol and the `done` pulse. The bench therefore compares `lineLow`, `busy` and `done` against a model in every cycle of the frame, so any fault shows within one symbol window. A fault in the end-of-frame logic shows by cycle 145. Frames use directed bytes (0x01, 0x00, 0xFF, 0x80) and seeded random bytes, and some frames receive a start pulse and a different `cmd` partway through.

// File: rtl/swire_req_pkg.sv
package swire_req_pkg;

  typedef struct packed {
    logic load;
    logic advance;
    logic finish;
  } txStrobe_t;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } txState_t;

endpackage

// File: rtl/swire_req_ctrl.sv
module swire_req_ctrl
  import swire_req_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      lastPhase,
  input  logic      lastSym,
  output txStrobe_t strobe,
  output logic      busy,
  output logic      done
);

  txState_t state;

  always_comb begin
    strobe         = '0;
    strobe.load    = (state == TX_IDLE) && start;
    strobe.finish  = (state == TX_SEND) && lastPhase && lastSym;
    strobe.advance = (state == TX_SEND) && !(lastPhase && lastSym);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= TX_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.load)        state <= TX_SEND;
      else if (strobe.finish) state <= TX_IDLE;
    end
  end

  assign busy = (state == TX_SEND);

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == TX_SEND && !strobe.finish) |=> (state == TX_SEND)); // R9

endmodule

// File: rtl/swire_req_datapath.sv
module swire_req_datapath
  import swire_req_pkg::*;
#(
  parameter int CMD_W      = 8,
  parameter int SYM_CYCLES = 16,
  parameter int LOW_ZERO   = 12,
  parameter int LOW_ONE    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        strobe,
  input  logic [CMD_W-1:0] cmdIn,
  output logic             lineLow,
  output logic             lastPhase,
  output logic             lastSym
);

  localparam int PH_W  = $clog2(SYM_CYCLES);
  localparam int SYM_W = $clog2(CMD_W + 1);
  localparam int RUN_W = $clog2(SYM_CYCLES + 1);

  logic [PH_W-1:0]  phase, nextPhase;
  logic [SYM_W-1:0] symIdx, nextSym;
  logic [CMD_W-1:0] shiftReg, nextShift;
  logic             nextLow;

  function automatic logic lowFor(input logic [PH_W-1:0] ph, input logic b);
    return int'(ph) < (b ? LOW_ONE : LOW_ZERO);
  endfunction

  assign lastPhase = (phase == PH_W'(SYM_CYCLES - 1));
  assign lastSym   = (symIdx == SYM_W'(CMD_W));

  always_comb begin
    nextPhase = phase;
    nextSym   = symIdx;
    nextShift = shiftReg;
    nextLow   = lineLow;
    if (strobe.load) begin
      nextPhase = '0;
      nextSym   = '0;
      nextShift = cmdIn;
      nextLow   = 1'b1;
    end else if (strobe.finish) begin
      nextLow = 1'b0;
    end else if (strobe.advance) begin
      if (lastPhase) begin
        nextPhase = '0;
        nextSym   = symIdx + 1'b1;
        // shift in ones so the stop symbol carries 1-timing
        nextShift = {shiftReg[CMD_W-2:0], 1'b1};
      end else begin
        nextPhase = phase + 1'b1;
      end
      nextLow = lowFor(nextPhase, nextShift[CMD_W-1]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= '0;
      symIdx   <= '0;
      shiftReg <= '0;
      lineLow  <= 1'b0;
    end else begin
      phase    <= nextPhase;
      symIdx   <= nextSym;
      shiftReg <= nextShift;
      lineLow  <= nextLow;
    end
  end

  // length of the current low stretch, used only by the check below
  logic [RUN_W-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lowRun <= '0;
    else if (lineLow) lowRun <= lowRun + 1'b1;
    else              lowRun <= '0;
  end

  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (!lineLow && lowRun != '0) |->
      (int'(lowRun) == LOW_ZERO || int'(lowRun) == LOW_ONE)); // R3

endmodule

// File: rtl/swire_req_tx.sv
module swire_req_tx
  import swire_req_pkg::*;
#(
  parameter int CMD_W      = 8,
  parameter int SYM_CYCLES = 16,
  parameter int LOW_ZERO   = 12,
  parameter int LOW_ONE    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CMD_W-1:0] cmd,
  output logic             lineLow,
  output logic             busy,
  output logic             done
);

  txStrobe_t strobe;
  logic      lastPhase;
  logic      lastSym;

  swire_req_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .lastPhase (lastPhase),
    .lastSym   (lastSym),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  swire_req_datapath #(
    .CMD_W      (CMD_W),
    .SYM_CYCLES (SYM_CYCLES),
    .LOW_ZERO   (LOW_ZERO),
    .LOW_ONE    (LOW_ONE)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdIn     (cmd),
    .lineLow   (lineLow),
    .lastPhase (lastPhase),
    .lastSym   (lastSym)
  );

  AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineLow); // R1

  AST_START_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> lineLow); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R8

endmodule

// File: tb/swire_req_tx_tb_top.sv
module swire_req_tx_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic       lineLow, busy, done;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  swire_req_tx dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd),
    .lineLow(lineLow), .busy(busy), .done(done)
  );

  // expected line level at sample n (1..144) after the start edge
  function automatic logic expLow(input logic [7:0] c, input int n);
    int k = n - 1;
    int sym = k / 16;
    int ph  = k % 16;
    logic b = (sym < 8) ? c[7 - sym] : 1'b1;
    return ph < (b ? 4 : 12);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sendFrame(input logic [7:0] c, input bit poke);
    @(negedge clk);
    start = 1'b1; cmd = c;
    @(negedge clk);
    start = 1'b0; cmd = ~c;      // R9: cmd change after capture
    for (int n = 1; n <= 144; n++) begin
      logic e = expLow(c, n);
      string tag = (n > 128) ? "R7" : (n == 1) ? "R2" : (e == 1'b0 && c == 8'h01) ? "R4" : "R5/R3 R6";
      check(lineLow === e, tag, lineLow, e);
      check(busy === 1'b1 && done === 1'b0, "R6 busy", {busy, done}, 2);
      if (poke && (n == 40 || n == 100)) begin
        start = 1'b1; cmd = 8'hA5;  // R9 start while busy
      end else if (poke) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(lineLow === 1'b0, "R7 released", lineLow, 0);
    check(busy === 1'b0 && done === 1'b1, "R8 done", {busy, done}, 1);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0 && lineLow === 1'b0, "R1 R8 idle", {lineLow, busy, done}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk);
    check(lineLow === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset", {lineLow, busy, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(lineLow === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 after reset", {lineLow, busy, done}, 0);
    sendFrame(8'h01, 1'b0);
    sendFrame(8'h00, 1'b0);   // R3 all-zero timing
    sendFrame(8'hFF, 1'b0);   // R4 all-one timing
    sendFrame(8'h80, 1'b0);   // R5 MSB first
    sendFrame(8'h01, 1'b1);   // R9 ignored start
    for (int i = 0; i < 20; i++) begin
      logic [7:0] r = 8'($urandom);
      sendFrame(r, ($urandom % 2) == 0);
      repeat ($urandom % 4) @(negedge clk);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule